// File: doc/BRIEF.md
# Translation Unit Control and Interrupt Register Bank

This block is the software-facing register file of one address translation unit. A host reaches it over a plain 32-bit register bus with a word address, a write enable, write data and registered read data. Through it, software sets the base of the translation table, issues mode commands and services faults. The table walker beside it reads the mode outputs and sends single-cycle event pulses back.

Commands are written as small numeric codes to one command register. Each valid code enters a fixed-latency pipeline. It changes the mode state a set number of cycles later, so software polls the status word to see it land. The supported actions are:
- translation on and off;
- stall entry and exit;
- whole-cache flush;
- fault acknowledge;
- a soft reset that zeroes every register.

Fault and bus-error pulses set raw interrupt flags. These flags are masked, cleared by write-one, and combined into one interrupt line.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: Register 0x00 holds the table base with bits 11:0 forced to zero (writing 0xCAFEBABE reads back 0xCAFEB000), and drives `table_base`.
- R2: A write to 0x08 with a value 0..6 is applied exactly CMD_LAT cycles after the write edge. Any value of 7 or above is ignored and does not clear the idle flag. Code 0 turns translation on.
- R3: Code 2 (stall) takes effect only if translation is on when the command is applied. `stall_on` never holds without `xlat_on`.
- R4: Code 3 releases the stall and keeps translation on. Code 1 turns translation off and also releases any stall.
- R5: Code 4 produces exactly one `flush_all` pulse, one cycle long, per command.
- R6: Code 5 clears the fault-active and fault-write flags. The fault address register keeps its value.
- R7: Code 6 zeroes all registers, the in-flight commands and all outputs. Afterwards the table base reads 0 and the status reads 0x80000018.
- R8: A fault pulse sets raw interrupt bit 0 and the fault-active flag, and captures the fault address (read at 0x0C) and the write flag.
- R9: A bus-error pulse sets raw interrupt bit 1.
- R10: Raw flags read at 0x14. Writing 1s to 0x18 clears those flags, but an event in the same cycle wins over the clear.
- R11: The mask is at 0x1C (bits 1:0) and the masked status is at 0x20 (raw AND mask). `irq` is the OR of the masked bits, registered one cycle later.
- R12: A write to 0x10 gives a one-cycle `flush_one` pulse, with `flush_one_page` equal to write data bits 31:12.
- R13: Status at 0x04 has these bits: bit 0 translation on, bit 1 fault active, bit 2 stall, bit 3 no command in flight, bit 4 equal to not fault active, bit 5 fault was a write, and bit 31 equal to not stall. All other bits are zero.
- R14: Register 0x24 holds one clock-gating enable bit (bit 0), which drives `clk_gate_en`. Read data appears one cycle after the address, and accesses with address bits 1:0 nonzero are ignored and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| evt_fault | input | 1 | Page fault pulse from the walker |
| evt_fault_write | input | 1 | The faulting access was a write |
| evt_fault_addr | input | DATA_W | Faulting address |
| evt_bus_err | input | 1 | Bus read error pulse from the walker |
| table_base | output | DATA_W | Translation table base |
| xlat_on | output | 1 | Translation enabled |
| stall_on | output | 1 | Stall active |
| flush_all | output | 1 | Whole-cache flush pulse |
| flush_one | output | 1 | Single-entry flush pulse |
| flush_one_page | output | DATA_W-PAGE_BITS | Page number for the single-entry flush |
| clk_gate_en | output | 1 | Clock gating enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a fault pulse arriving in the cycle a write-one clear hits the same flag. Another is a stall command applied in the very cycle after translation switches on. The stimulus drives the fault pulse and the clear write on one shared clock edge. It also issues the enable and stall codes on consecutive cycles, so the stall is judged one cycle after the enable lands. A behavioural model with a time-stamped command queue predicts every output on every clock, so the cycle in which each command lands is checked as well as the final state.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;
  // word indices of the registers (byte offset / 4)
  localparam int IX_BASE   = 0;
  localparam int IX_STAT   = 1;
  localparam int IX_CMD    = 2;
  localparam int IX_FADDR  = 3;
  localparam int IX_FLUSH1 = 4;
  localparam int IX_RAW    = 5;
  localparam int IX_CLR    = 6;
  localparam int IX_MASK   = 7;
  localparam int IX_MSTAT  = 8;
  localparam int IX_GATE   = 9;

  localparam int CMD_W    = 3;
  localparam int NUM_CMDS = 7;

  typedef enum logic [CMD_W-1:0] {
    CMD_XLAT_ON    = 3'd0,
    CMD_XLAT_OFF   = 3'd1,
    CMD_STALL_ON   = 3'd2,
    CMD_STALL_OFF  = 3'd3,
    CMD_FLUSH_ALL  = 3'd4,
    CMD_FAULT_DONE = 3'd5,
    CMD_SOFT_RST   = 3'd6
  } cmd_e;

  localparam int IRQ_FAULT  = 0;
  localparam int IRQ_BUSERR = 1;
  localparam int NUM_IRQ    = 2;

  // status word bit positions
  localparam int ST_XLAT   = 0;
  localparam int ST_FAULT  = 1;
  localparam int ST_STALL  = 2;
  localparam int ST_IDLE   = 3;
  localparam int ST_REPLAY = 4;
  localparam int ST_FWRITE = 5;
endpackage

// File: rtl/xlat_cmd_pipe.sv
module xlat_cmd_pipe #(
  parameter int LAT = 3,
  parameter int CW  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [CW-1:0] code_in,
  output logic          apply_vld,
  output logic [CW-1:0] apply_code,
  output logic          busy
);
  logic [LAT-1:0]         vld_q;
  logic [LAT-1:0][CW-1:0] code_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clr) vld_q <= '0;
        else            vld_q <= push;
        code_q <= code_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst || clr) vld_q <= '0;
        else            vld_q <= {vld_q[LAT-2:0], push};
        code_q <= {code_q[LAT-2:0], code_in};
      end
    end
  endgenerate

  assign apply_vld  = vld_q[LAT-1];
  assign apply_code = code_q[LAT-1];
  assign busy       = |vld_q;

  p_push_busy_r13: assert property (@(posedge clk) disable iff (rst)
    (push && !clr) |=> busy);
endmodule

// File: rtl/xlat_mode_state.sv
module xlat_mode_state
  import xlat_regs_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             apply_vld,
  input  logic [CMD_W-1:0] apply_code,
  input  logic             evt_fault,
  input  logic             evt_write,
  input  logic [AW-1:0]    evt_addr,
  output logic             xlat_on,
  output logic             stall_on,
  output logic             fault_active,
  output logic             fault_write,
  output logic [AW-1:0]    fault_addr,
  output logic             flush_all
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      xlat_on      <= 1'b0;
      stall_on     <= 1'b0;
      fault_active <= 1'b0;
      fault_write  <= 1'b0;
      fault_addr   <= '0;
      flush_all    <= 1'b0;
    end else begin
      flush_all <= apply_vld && (apply_code == CMD_FLUSH_ALL);
      if (apply_vld) begin
        case (apply_code)
          CMD_XLAT_ON:   xlat_on <= 1'b1;
          CMD_XLAT_OFF: begin
            xlat_on  <= 1'b0;
            stall_on <= 1'b0;
          end
          CMD_STALL_ON:  if (xlat_on) stall_on <= 1'b1;
          CMD_STALL_OFF: stall_on <= 1'b0;
          CMD_FAULT_DONE: begin
            fault_active <= 1'b0;
            fault_write  <= 1'b0;
          end
          default: ;
        endcase
      end
      if (evt_fault) begin
        fault_active <= 1'b1;
        fault_write  <= evt_write;
        fault_addr   <= evt_addr;
      end
    end
  end

  p_stall_needs_xlat_r3: assert property (@(posedge clk) disable iff (rst)
    stall_on |-> xlat_on);

  p_stall_release_r4: assert property (@(posedge clk) disable iff (rst)
    (apply_vld && apply_code == CMD_STALL_OFF) |=> !stall_on);

  p_fault_done_r6: assert property (@(posedge clk) disable iff (rst)
    (apply_vld && apply_code == CMD_FAULT_DONE && !evt_fault && !clr)
      |=> (!fault_active && !fault_write && $stable(fault_addr)));

  p_fault_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_fault && !clr) |=> (fault_active && fault_addr == $past(evt_addr)));
endmodule

// File: rtl/xlat_irq_ctrl.sv
module xlat_irq_ctrl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_all,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] clr_bits,
  input  logic            mask_wr,
  input  logic [NSRC-1:0] mask_bits,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] mask,
  output logic            irq
);
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      logic r_q;
      always_ff @(posedge clk) begin
        if (rst || clr_all)            r_q <= 1'b0;
        else if (evt[i])               r_q <= 1'b1;
        else if (clr_wr && clr_bits[i]) r_q <= 1'b0;
      end
      assign raw[i] = r_q;

      p_event_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (evt[i] && !clr_all) |=> raw[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      mask <= '0;
      irq  <= 1'b0;
    end else begin
      if (mask_wr) mask <= mask_bits;
      irq <= |(raw & mask);
    end
  end

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_all) && !$past(rst)) |-> (irq == $past(|(raw & mask))));
endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
  import xlat_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int CMD_LAT   = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_we,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic                        evt_fault,
  input  logic                        evt_fault_write,
  input  logic [DATA_W-1:0]           evt_fault_addr,
  input  logic                        evt_bus_err,
  output logic [DATA_W-1:0]           table_base,
  output logic                        xlat_on,
  output logic                        stall_on,
  output logic                        flush_all,
  output logic                        flush_one,
  output logic [DATA_W-PAGE_BITS-1:0] flush_one_page,
  output logic                        clk_gate_en,
  output logic                        irq
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int PAGE_W = DATA_W - PAGE_BITS;

  logic             aligned;
  logic [IDX_W-1:0] idx;
  logic             wr_hit;
  logic             wr_base, wr_cmd, wr_flush1, wr_clr, wr_mask, wr_gate;
  logic             cmd_known;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign idx       = bus_addr[ADDR_W-1:2];
  assign wr_hit    = bus_we && aligned;
  assign cmd_known = (bus_wdata < DATA_W'(NUM_CMDS));
  assign wr_base   = wr_hit && (idx == IDX_W'(IX_BASE));
  assign wr_cmd    = wr_hit && (idx == IDX_W'(IX_CMD)) && cmd_known;
  assign wr_flush1 = wr_hit && (idx == IDX_W'(IX_FLUSH1));
  assign wr_clr    = wr_hit && (idx == IDX_W'(IX_CLR));
  assign wr_mask   = wr_hit && (idx == IDX_W'(IX_MASK));
  assign wr_gate   = wr_hit && (idx == IDX_W'(IX_GATE));

  // command pipeline
  logic             apply_vld;
  logic [CMD_W-1:0] apply_code;
  logic             cmd_busy;
  logic             soft_rst;

  assign soft_rst = apply_vld && (apply_code == CMD_SOFT_RST);

  xlat_cmd_pipe #(.LAT(CMD_LAT), .CW(CMD_W)) u_pipe (
    .clk        (clk),
    .rst        (rst),
    .clr        (soft_rst),
    .push       (wr_cmd),
    .code_in    (bus_wdata[CMD_W-1:0]),
    .apply_vld  (apply_vld),
    .apply_code (apply_code),
    .busy       (cmd_busy)
  );

  // mode and fault state
  logic              fault_active, fault_write;
  logic [DATA_W-1:0] fault_addr;

  xlat_mode_state #(.AW(DATA_W)) u_mode (
    .clk          (clk),
    .rst          (rst),
    .clr          (soft_rst),
    .apply_vld    (apply_vld),
    .apply_code   (apply_code),
    .evt_fault    (evt_fault),
    .evt_write    (evt_fault_write),
    .evt_addr     (evt_fault_addr),
    .xlat_on      (xlat_on),
    .stall_on     (stall_on),
    .fault_active (fault_active),
    .fault_write  (fault_write),
    .fault_addr   (fault_addr),
    .flush_all    (flush_all)
  );

  // interrupt flags
  logic [NUM_IRQ-1:0] irq_evt, irq_raw, irq_mask;
  assign irq_evt[IRQ_FAULT]  = evt_fault;
  assign irq_evt[IRQ_BUSERR] = evt_bus_err;

  xlat_irq_ctrl #(.NSRC(NUM_IRQ)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .clr_all   (soft_rst),
    .evt       (irq_evt),
    .clr_wr    (wr_clr),
    .clr_bits  (bus_wdata[NUM_IRQ-1:0]),
    .mask_wr   (wr_mask),
    .mask_bits (bus_wdata[NUM_IRQ-1:0]),
    .raw       (irq_raw),
    .mask      (irq_mask),
    .irq       (irq)
  );

  // plain registers
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      table_base     <= '0;
      clk_gate_en    <= 1'b0;
      flush_one      <= 1'b0;
      flush_one_page <= '0;
    end else begin
      if (wr_base) table_base <= {bus_wdata[DATA_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
      if (wr_gate) clk_gate_en <= bus_wdata[0];
      flush_one <= wr_flush1;
      if (wr_flush1) flush_one_page <= bus_wdata[DATA_W-1:PAGE_BITS];
    end
  end

  // status word and read mux
  logic [DATA_W-1:0] status_w, rd_mux;

  always_comb begin
    status_w            = '0;
    status_w[ST_XLAT]   = xlat_on;
    status_w[ST_FAULT]  = fault_active;
    status_w[ST_STALL]  = stall_on;
    status_w[ST_IDLE]   = !cmd_busy;
    status_w[ST_REPLAY] = !fault_active;
    status_w[ST_FWRITE] = fault_write;
    status_w[DATA_W-1]  = !stall_on;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      case (idx)
        IDX_W'(IX_BASE):  rd_mux = table_base;
        IDX_W'(IX_STAT):  rd_mux = status_w;
        IDX_W'(IX_FADDR): rd_mux = fault_addr;
        IDX_W'(IX_RAW):   rd_mux = {{(DATA_W-NUM_IRQ){1'b0}}, irq_raw};
        IDX_W'(IX_MASK):  rd_mux = {{(DATA_W-NUM_IRQ){1'b0}}, irq_mask};
        IDX_W'(IX_MSTAT): rd_mux = {{(DATA_W-NUM_IRQ){1'b0}}, irq_raw & irq_mask};
        IDX_W'(IX_GATE):  rd_mux = {{(DATA_W-1){1'b0}}, clk_gate_en};
        default:          rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) bus_rdata <= '0;
    else                 bus_rdata <= rd_mux;
  end

  p_base_write_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_base && !soft_rst) |=>
      (table_base == {$past(bus_wdata[DATA_W-1:PAGE_BITS]), {PAGE_BITS{1'b0}}}));

  p_xlat_rise_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(xlat_on) |-> $past(apply_vld && apply_code == CMD_XLAT_ON));

  p_flush_source_r5: assert property (@(posedge clk) disable iff (rst)
    flush_all |-> $past(apply_vld && apply_code == CMD_FLUSH_ALL));

  p_soft_reset_r7: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (table_base == '0 && !xlat_on && !irq && !clk_gate_en));

  p_flush_one_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_flush1 && !soft_rst) |=> (flush_one && flush_one_page == $past(bus_wdata[DATA_W-1:PAGE_BITS])));
endmodule

// File: tb/xlat_ctrl_regs_test.sv
module xlat_ctrl_regs_test;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        evt_fault = 1'b0, evt_fault_write = 1'b0, evt_bus_err = 1'b0;
  logic [31:0] evt_fault_addr = '0;
  logic [31:0] table_base;
  logic        xlat_on, stall_on, flush_all, flush_one, clk_gate_en, irq;
  logic [19:0] flush_one_page;

  always #2 clk = ~clk;

  xlat_ctrl_regs #(.CMD_LAT(LAT)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_fault(evt_fault), .evt_fault_write(evt_fault_write),
    .evt_fault_addr(evt_fault_addr), .evt_bus_err(evt_bus_err),
    .table_base(table_base), .xlat_on(xlat_on), .stall_on(stall_on),
    .flush_all(flush_all), .flush_one(flush_one),
    .flush_one_page(flush_one_page), .clk_gate_en(clk_gate_en), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // ---------------- reference model ----------------
  int          cyc = 0;
  logic [31:0] m_base, m_faddr;
  logic        m_xlat, m_stall, m_fact, m_fwr, m_gate;
  logic [1:0]  m_raw, m_mask;
  int          q_due[$];
  int          q_code[$];
  logic [31:0] e_rdata;
  logic        e_irq, e_fa, e_f1;
  logic [19:0] e_f1p;

  function automatic logic [31:0] mread(logic [7:0] a, logic idle);
    if (a[1:0] != 2'b00) return 32'h0;
    case (a[7:2])
      6'd0: return m_base;
      6'd1: return {~m_stall, 25'b0, m_fwr, ~m_fact, idle, m_stall, m_fact, m_xlat};
      6'd3: return m_faddr;
      6'd5: return {30'b0, m_raw};
      6'd7: return {30'b0, m_mask};
      6'd8: return {30'b0, m_raw & m_mask};
      6'd9: return {31'b0, m_gate};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [7:0] a);
    case (a)
      8'h00: return "R1 base readback";
      8'h04: return "R13 status";
      8'h0C: return "R8 fault address";
      8'h14: return "R10 raw flags";
      8'h1C, 8'h20: return "R11 mask/masked";
      8'h24: return "R14 gate";
      default: return "R14 read data";
    endcase
  endfunction

  task automatic mzero();
    m_base = 0; m_faddr = 0; m_xlat = 0; m_stall = 0; m_fact = 0; m_fwr = 0;
    m_gate = 0; m_raw = 0; m_mask = 0;
    q_due.delete(); q_code.delete();
    e_rdata = 0; e_irq = 0; e_fa = 0; e_f1 = 0; e_f1p = 0;
  endtask

  logic [7:0] prev_addr = '0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mzero();
    end else begin
      int          app;
      logic        idle_now;
      logic [31:0] rd_v;
      logic        irq_v;
      app      = -1;
      idle_now = (q_due.size() == 0);
      rd_v     = mread(bus_addr, idle_now);
      irq_v    = |(m_raw & m_mask);
      if (q_due.size() > 0 && q_due[0] == cyc) begin
        app = q_code[0];
        void'(q_due.pop_front());
        void'(q_code.pop_front());
      end
      if (app == 6) begin
        mzero();
      end else begin
        e_rdata = rd_v;
        e_irq   = irq_v;
        e_fa    = (app == 4);
        e_f1    = bus_we && bus_addr == 8'h10;
        if (e_f1) e_f1p = bus_wdata[31:12];
        case (app)
          0: m_xlat = 1;
          1: begin m_xlat = 0; m_stall = 0; end
          2: if (m_xlat) m_stall = 1;
          3: m_stall = 0;
          5: begin m_fact = 0; m_fwr = 0; end
          default: ;
        endcase
        if (bus_we) begin
          case (bus_addr)
            8'h00: m_base = {bus_wdata[31:12], 12'h000};
            8'h08: if (bus_wdata < 7) begin
                     q_due.push_back(cyc + LAT);
                     q_code.push_back(int'(bus_wdata));
                   end
            8'h18: m_raw = m_raw & ~bus_wdata[1:0];
            8'h1C: m_mask = bus_wdata[1:0];
            8'h24: m_gate = bus_wdata[0];
            default: ;
          endcase
        end
        if (evt_fault) begin
          m_raw[0] = 1; m_fact = 1; m_fwr = evt_fault_write; m_faddr = evt_fault_addr;
        end
        if (evt_bus_err) m_raw[1] = 1;
      end
    end
    prev_addr <= bus_addr;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (cyc >= 1) begin
      chk(rtag(prev_addr), bus_rdata, e_rdata);
      chk("R1 table_base port", table_base, m_base);
      chk("R2 xlat_on", {31'b0, xlat_on}, {31'b0, m_xlat});
      chk("R3 stall_on", {31'b0, stall_on}, {31'b0, m_stall});
      chk("R5 flush_all", {31'b0, flush_all}, {31'b0, e_fa});
      chk("R12 flush_one", {31'b0, flush_one}, {31'b0, e_f1});
      if (e_f1) chk("R12 flush_one_page", {12'b0, flush_one_page}, {12'b0, e_f1p});
      chk("R11 irq", {31'b0, irq}, {31'b0, e_irq});
      chk("R14 clk_gate_en", {31'b0, clk_gate_en}, {31'b0, m_gate});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic poll(string tag, logic [31:0] m, logic [31:0] exp);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 40; i++) begin
      rd(8'h04, v);
      if ((v & m) == exp) break;
    end
    chk(tag, v & m, exp);
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int          pulses;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    rd(8'h04, v); chk("R13 status after reset", v, 32'h8000_0018);
    rd(8'h00, v); chk("R1 base after reset", v, 32'h0);

    wr(8'h00, 32'hCAFE_BABE);
    rd(8'h00, v); chk("R1 base keeps upper bits", v, 32'hCAFE_B000);

    // stall while translation off: no effect
    wr(8'h08, 32'd2); idle_cycles(LAT + 2);
    rd(8'h04, v); chk("R3 stall ignored when off", v & 32'h4, 32'h0);

    // enable translation
    wr(8'h08, 32'd0);
    poll("R2 translation on", 32'h1, 32'h1);
    // unknown code ignored
    wr(8'h08, 32'd7);
    rd(8'h04, v); chk("R2 unknown code keeps idle", v & 32'h9, 32'h9);
    idle_cycles(LAT + 2);
    rd(8'h04, v); chk("R2 unknown code no effect", v, 32'h8000_0019);

    // stall enter / leave
    wr(8'h08, 32'd2);
    poll("R3 stall entered", 32'h8000_0004, 32'h4);
    wr(8'h08, 32'd3);
    poll("R4 stall left", 32'h8000_0005, 32'h8000_0001);
    wr(8'h08, 32'd2);
    poll("R3 stall again", 32'h4, 32'h4);
    wr(8'h08, 32'd1);
    poll("R4 disable drops stall", 32'h8000_0005, 32'h8000_0000);

    // back-to-back: enable then stall on consecutive cycles
    @(negedge clk);
    bus_addr = 8'h08; bus_we = 1'b1; bus_wdata = 32'd0;
    @(negedge clk);
    bus_wdata = 32'd2;
    @(negedge clk);
    bus_we = 1'b0;
    poll("R3 stall right after enable", 32'h5, 32'h5);

    // fault handling
    wr(8'h1C, 32'h3);
    @(negedge clk);
    evt_fault = 1'b1; evt_fault_write = 1'b1; evt_fault_addr = 32'h1234_5678;
    @(negedge clk);
    evt_fault = 1'b0; evt_fault_write = 1'b0;
    @(negedge clk);
    chk("R11 irq on masked fault", {31'b0, irq}, 32'h1);
    rd(8'h0C, v); chk("R8 fault address", v, 32'h1234_5678);
    rd(8'h04, v); chk("R8 fault flags in status", v & 32'h32, 32'h22);
    rd(8'h20, v); chk("R11 masked status", v, 32'h1);
    wr(8'h08, 32'd5);
    poll("R6 fault done clears active", 32'h32, 32'h10);
    rd(8'h0C, v); chk("R6 fault address held", v, 32'h1234_5678);

    // clear colliding with a new fault
    @(negedge clk);
    bus_addr = 8'h18; bus_we = 1'b1; bus_wdata = 32'h1;
    evt_fault = 1'b1; evt_fault_addr = 32'h0000_5000;
    @(negedge clk);
    bus_we = 1'b0; evt_fault = 1'b0;
    rd(8'h14, v); chk("R10 event wins over clear", v & 32'h1, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h14, v); chk("R10 write-one clear", v, 32'h0);
    @(negedge clk);
    chk("R11 irq drops after clear", {31'b0, irq}, 32'h0);

    // bus error with mask off
    wr(8'h1C, 32'h0);
    @(negedge clk); evt_bus_err = 1'b1;
    @(negedge clk); evt_bus_err = 1'b0;
    rd(8'h14, v); chk("R9 bus error flag", v, 32'h2);
    chk("R11 masked off no irq", {31'b0, irq}, 32'h0);
    rd(8'h20, v); chk("R11 masked status zero", v, 32'h0);
    wr(8'h18, 32'h2);

    // whole-cache flush: exactly one pulse
    wr(8'h08, 32'd4);
    pulses = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (flush_all) pulses++;
    end
    chk("R5 one flush pulse", pulses, 1);

    // single-entry flush
    wr(8'h10, 32'hABCD_E123);
    chk("R12 flush_one pulse", {31'b0, flush_one}, 32'h1);
    chk("R12 flush page", {12'b0, flush_one_page}, 32'h000A_BCDE);

    // gating and misaligned
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); chk("R14 gate bit", v, 32'h1);
    wr(8'h25, 32'h0);
    rd(8'h24, v); chk("R14 misaligned write ignored", v, 32'h1);

    // soft reset
    wr(8'h00, 32'hCAFE_BABE);
    wr(8'h1C, 32'h3);
    wr(8'h08, 32'd6);
    for (int i = 0; i < 40; i++) begin
      rd(8'h00, v);
      if (v == 32'h0) break;
    end
    chk("R7 base zero after soft reset", v, 32'h0);
    rd(8'h04, v); chk("R7 status after soft reset", v, 32'h8000_0018);
    rd(8'h1C, v); chk("R7 mask cleared", v, 32'h0);
    rd(8'h24, v); chk("R7 gate cleared", v, 32'h0);

    idle_cycles(4);
    finish_run();
  end
endmodule